// File: doc/BRIEF.md
# Password-Protected Watchdog Timer

This block is a watchdog timer with two word-addressed registers on a simple synchronous bus. A control register holds the whole configuration: run enable, early-warning fraction, tick divider and a 16-bit reload value. Software can change it only through a two-write key handshake. A first write arms the lock and a second, immediately following write commits the new configuration in one step.

Each committed write also services the watchdog. The counter is reloaded, the divider phase restarts and the warning and expiry state clears. While enabled, the counter steps down once per divided tick. A sticky warning flag rises when the count falls to a chosen fraction of the reload value. A single-cycle reset request is issued when the count reaches zero. A read-only status register shows the enable, warning, expired and live count values.

Top module: `pwd_watchdog`

## Requirements
- R1: After reset the watchdog is disabled, the count is 0, warn_o and expire_o are low, and both registers read as 0.
- R2: A write to offset 0x0 with key field bits 23:16 = 0xBE arms the lock. If the next bus access is a write to 0x0 with key 0xDC, that write commits bit 31 (enable), bits 27:26 (warning select), bits 25:24 (divider select) and bits 15:0 (reload). A read of 0x0 then returns those fields in the same positions, with all other bits 0.
- R3: A write to 0x0 with key 0xDC that does not directly follow an arming write changes nothing. An armed write carrying any other key disarms the lock.
- R4: Any bus access between the arming write and the commit write disarms the lock, whether it is a read, or a write to another offset. The commit write that follows is then ignored.
- R5: The status register at offset 0x8 is read-only. Writes to it change no state. Its layout is bit 31 enable, bit 30 warning, bit 29 expired and bits 15:0 the count. Other offsets read as 0.
- R6: Divider select d gives one tick every 2^(d*DIV_STEP) clocks, with the phase restarting at each commit. With enable set and reload N ≥ 1, expire_o pulses exactly N*2^(d*DIV_STEP) clocks after the committing edge.
- R7: Warning select w (0..3 meaning 1/2, 1/4, 1/8, 1/16) sets warn_o at the first tick that leaves the count at or below reload >> (w+1). warn_o then stays high until the next commit.
- R8: expire_o is high for exactly one cycle. The expired status bit is then set, the count stays at 0, and no further pulse occurs until a commit.
- R9: A commit reloads the count from the new reload value and clears warn_o and the expired bit, which services a running watchdog.
- R10: A commit with bit 31 clear disables the watchdog. The count holds the new reload value and no pulse occurs.
- R11: When a commit lands on the same clock edge as the tick that would expire the count, the commit wins and no pulse is issued for that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read |
| warn_o | output | 1 | Sticky early-warning flag |
| expire_o | output | 1 | One-cycle reset request |

## Verification
Two functions can meet in one clock edge: a servicing commit and the tick that drives the count to zero. The bench provokes this by counting edges from a commit with a divide-by-one tick and reload 5, so that the next commit lands exactly on the fifth edge. It then requires that no pulse appears and that the count reads back as 5. The warning and the expiry can also coincide: with reload 1, every warning fraction rounds to 0, and the bench requires both flags to rise on the same edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W = 16;
  localparam int KEY_W = 8;
  localparam logic [KEY_W-1:0] KEY_ARM    = 8'hBE;
  localparam logic [KEY_W-1:0] KEY_COMMIT = 8'hDC;
  localparam int CTRL_OFS    = 0;
  localparam int STAT_OFS    = 8;
  localparam int EN_BIT      = 31;
  localparam int WSEL_LSB    = 26;
  localparam int DSEL_LSB    = 24;
  localparam int KEY_LSB     = 16;
  localparam int ST_WARN_BIT = 30;
  localparam int ST_EXP_BIT  = 29;

  typedef struct packed {
    logic             en;
    logic [1:0]       warn_sel;
    logic [1:0]       div_sel;
    logic [CNT_W-1:0] reload;
  } wdt_cfg_t;

  // Warning threshold: reload scaled by 1/2, 1/4, 1/8 or 1/16.
  function automatic logic [CNT_W-1:0] warn_limit(input logic [CNT_W-1:0] reload,
                                                  input logic [1:0] sel);
    return reload >> (32'(sel) + 32'd1);
  endfunction

  // Last prescaler phase before a tick: 2^(sel*step) - 1.
  function automatic int unsigned tick_last(input logic [1:0] sel, input int unsigned step);
    return (32'd1 << (32'(sel) * step)) - 32'd1;
  endfunction
endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             wr,
  input  logic             hit_ctrl,
  input  logic [KEY_W-1:0] key,
  output logic             accept,
  output logic             armed
);
  typedef enum logic {UL_IDLE, UL_ARMED} ul_state_t;
  ul_state_t st_q, st_d;

  always_comb begin
    accept = (st_q == UL_ARMED) && acc && wr && hit_ctrl && (key == KEY_COMMIT);
    st_d   = st_q;
    if (acc) begin
      // Any access either arms (from idle with the first key) or returns to idle.
      st_d = (st_q == UL_IDLE && wr && hit_ctrl && key == KEY_ARM) ? UL_ARMED : UL_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= UL_IDLE;
    else        st_q <= st_d;
  end

  assign armed = (st_q == UL_ARMED);

  // R2: a commit always leaves the lock idle
  a_r2_commit_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !armed);
  // R4: any access while armed ends the armed state
  a_r4_access_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && acc) |=> !armed);
  // R2: the lock arms only after a control write carrying the first key
  a_r2_arm_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(acc && wr && hit_ctrl && key == KEY_ARM));
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale
  import wdt_pkg::*;
#(
  parameter int DIV_STEP = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] div_sel,
  output logic       tick
);
  localparam int PW = 3 * DIV_STEP + 1;

  logic [PW-1:0] pre_q;
  logic [PW-1:0] last;

  assign last = PW'(tick_last(div_sel, DIV_STEP));
  assign tick = run && (pre_q == last);

  always_ff @(posedge clk) begin
    if (!rst_n)                       pre_q <= '0;
    else if (restart || !run || tick) pre_q <= '0;
    else                              pre_q <= pre_q + 1'b1;
  end

  // R6: with a divider above one, ticks are never back to back
  a_r6_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && div_sel != 2'd0) |=> !tick);
  // R6: the phase never runs past the selected period
  a_r6_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pre_q <= last));
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] new_reload,
  input  wdt_cfg_t         cfg,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             warn,
  output logic             expired,
  output logic             pulse
);
  logic [CNT_W-1:0] cnt_q, nxt, thr;
  logic             warn_q, exp_q, pulse_q, step;

  always_comb begin
    nxt  = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
    thr  = warn_limit(cfg.reload, cfg.warn_sel);
    step = cfg.en && tick && !exp_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      warn_q  <= 1'b0;
      exp_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else if (load) begin
      cnt_q   <= new_reload;
      warn_q  <= 1'b0;
      exp_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (step) begin
        cnt_q <= nxt;
        if (nxt <= thr) warn_q <= 1'b1;
        if (nxt == '0) begin
          exp_q   <= 1'b1;
          pulse_q <= 1'b1;
        end
      end
    end
  end

  assign cnt     = cnt_q;
  assign warn    = warn_q;
  assign expired = exp_q;
  assign pulse   = pulse_q;

  // R8: the reset request lasts one cycle
  a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
  // R8: a pulse coincides with an empty, expired counter
  a_r8_pulse_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (cnt_q == '0 && exp_q));
  // R8: no repeated pulse until a reload
  a_r8_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_q && !load) |=> !pulse_q);
  // R7: warning is sticky until a reload
  a_r7_warn_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_q && !load) |=> warn_q);
  // R10: a disabled counter holds its value
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.en && !load) |=> $stable(cnt_q));
  // R11: a reload wins over a coinciding expiry tick
  a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!pulse_q && !exp_q && !warn_q));
endmodule

// File: rtl/pwd_watchdog.sv
module pwd_watchdog
  import wdt_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DIV_STEP = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              warn_o,
  output logic              expire_o
);
  logic             hit_ctrl, hit_stat, accept, armed, tick;
  logic             warn, expired, pulse;
  logic [CNT_W-1:0] cnt;
  wdt_cfg_t         cfg_q, cfg_new;
  logic             unused_bits;

  assign hit_ctrl    = (bus_addr == ADDR_W'(CTRL_OFS));
  assign hit_stat    = (bus_addr == ADDR_W'(STAT_OFS));
  assign unused_bits = ^bus_wdata[30:28];

  always_comb begin
    cfg_new.en       = bus_wdata[EN_BIT];
    cfg_new.warn_sel = bus_wdata[WSEL_LSB +: 2];
    cfg_new.div_sel  = bus_wdata[DSEL_LSB +: 2];
    cfg_new.reload   = bus_wdata[CNT_W-1:0];
  end

  wdt_unlock u_unlock (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (bus_sel),
    .wr       (bus_wr),
    .hit_ctrl (hit_ctrl),
    .key      (bus_wdata[KEY_LSB +: KEY_W]),
    .accept   (accept),
    .armed    (armed)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (accept) cfg_q <= cfg_new;
  end

  wdt_prescale #(.DIV_STEP(DIV_STEP)) u_prescale (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (cfg_q.en),
    .restart (accept),
    .div_sel (cfg_q.div_sel),
    .tick    (tick)
  );

  wdt_countdown u_countdown (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .new_reload (cfg_new.reload),
    .cfg        (cfg_q),
    .tick       (tick),
    .cnt        (cnt),
    .warn       (warn),
    .expired    (expired),
    .pulse      (pulse)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (hit_ctrl) begin
        bus_rdata[EN_BIT]            = cfg_q.en;
        bus_rdata[WSEL_LSB +: 2]     = cfg_q.warn_sel;
        bus_rdata[DSEL_LSB +: 2]     = cfg_q.div_sel;
        bus_rdata[CNT_W-1:0]         = cfg_q.reload;
      end else if (hit_stat) begin
        bus_rdata[EN_BIT]            = cfg_q.en;
        bus_rdata[ST_WARN_BIT]       = warn;
        bus_rdata[ST_EXP_BIT]        = expired;
        bus_rdata[CNT_W-1:0]         = cnt;
      end
    end
  end

  assign warn_o   = warn;
  assign expire_o = pulse;

  // R3: configuration changes only on a commit
  a_r3_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(cfg_q));
  // R8: a reset request only comes from an enabled watchdog
  a_r8_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |-> cfg_q.en);
  // R2: a commit is only possible from the armed state
  a_r2_commit_when_armed: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> armed);
endmodule

// File: tb/test_pwd_watchdog.sv
module test_pwd_watchdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        warn_o, expire_o;
  int          vec = 0;
  int          miss = 0;
  int          pulses = 0;
  localparam int STEP = 2;

  always #4 clk = ~clk;

  pwd_watchdog #(.ADDR_W(4), .DIV_STEP(STEP)) i_pwd_watchdog (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .warn_o(warn_o), .expire_o(expire_o)
  );

  always @(negedge clk) if (rst_n && expire_o) pulses++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cw(input logic en, input logic [1:0] ws,
                                     input logic [1:0] ds, input logic [15:0] rl);
    return {en, 3'b000, ws, ds, 8'h00, rl};
  endfunction

  function automatic logic [31:0] sw(input logic en, input logic wn,
                                     input logic ex, input logic [15:0] c);
    return {en, wn, ex, 13'd0, c};
  endfunction

  task automatic bw(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic br(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic unlock(input logic [31:0] d);
    bw(4'h0, 32'h00BE_0000);
    bw(4'h0, d | 32'h00DC_0000);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 warn_o", {31'd0, warn_o}, 32'd0);
    chk("R1 expire_o", {31'd0, expire_o}, 32'd0);
    br(4'h8, d); chk("R1 status", d, 32'd0);
    br(4'h0, d); chk("R1 control", d, 32'd0);
  endtask

  task automatic t_lock;
    logic [31:0] d;
    bw(4'h0, cw(1, 0, 0, 9) | 32'h00DC_0000);
    br(4'h8, d); chk("R3 lone commit", d, 32'd0);
    bw(4'h0, 32'h00BE_0000);
    bw(4'h0, cw(1, 0, 0, 9) | 32'h0012_0000);
    bw(4'h0, cw(1, 0, 0, 9) | 32'h00DC_0000);
    br(4'h8, d); chk("R3 wrong key", d, 32'd0);
  endtask

  task automatic t_abort;
    logic [31:0] d;
    bw(4'h0, 32'h00BE_0000);
    br(4'h8, d);
    bw(4'h0, cw(1, 0, 0, 9) | 32'h00DC_0000);
    br(4'h0, d); chk("R4 read aborts", d, 32'd0);
    bw(4'h0, 32'h00BE_0000);
    bw(4'h8, 32'h1234_5678);
    bw(4'h0, cw(1, 0, 0, 9) | 32'h00DC_0000);
    br(4'h0, d); chk("R4 status write aborts", d, 32'd0);
  endtask

  task automatic t_status_ro;
    logic [31:0] d;
    bw(4'h8, 32'hFFFF_FFFF);
    br(4'h8, d); chk("R5 status write ignored", d, 32'd0);
    br(4'h0, d); chk("R5 control untouched", d, 32'd0);
    br(4'h4, d); chk("R5 other offset", d, 32'd0);
  endtask

  task automatic t_config;
    logic [31:0] d;
    unlock(cw(1, 2, 1, 16'd40));
    br(4'h0, d); chk("R2 control readback", d, cw(1, 2, 1, 16'd40));
  endtask

  task automatic t_run(input int ws, input int ds, input int n);
    logic [31:0] d;
    int L, thr, kw, ke, fw, fe, np;
    L = 1 << (ds * STEP);
    thr = n >> (ws + 1);
    kw = (n - thr) * L;
    ke = n * L;
    fw = 0; fe = 0; np = 0;
    unlock(cw(1, 2'(ws), 2'(ds), 16'(n)));
    for (int k = 1; k <= ke + 2 * L; k++) begin
      @(posedge clk); #1;
      if (warn_o && fw == 0) fw = k;
      if (expire_o) begin
        np++;
        if (fe == 0) fe = k;
      end
    end
    chk($sformatf("R7 warn edge ws=%0d ds=%0d n=%0d", ws, ds, n), 32'(fw), 32'(kw));
    chk($sformatf("R6 expiry edge ws=%0d ds=%0d n=%0d", ws, ds, n), 32'(fe), 32'(ke));
    chk("R8 single pulse", 32'(np), 32'd1);
    br(4'h8, d); chk("R8 expired status", d, sw(1, 1, 1, 16'd0));
  endtask

  task automatic t_service;
    logic [31:0] d;
    unlock(cw(1, 0, 0, 16'd30));
    br(4'h8, d); chk("R9 reload clears expiry", d, sw(1, 0, 0, 16'd30));
    repeat (20) @(posedge clk);
    #1 chk("R7 warn set before service", {31'd0, warn_o}, 32'd1);
    unlock(cw(1, 0, 0, 16'd30));
    chk("R9 warn cleared", {31'd0, warn_o}, 32'd0);
    br(4'h8, d); chk("R9 count reloaded", d, sw(1, 0, 0, 16'd30));
  endtask

  task automatic t_disable;
    logic [31:0] d;
    int p0;
    unlock(cw(1, 0, 0, 16'd50));
    repeat (5) @(posedge clk);
    unlock(cw(0, 0, 0, 16'd7));
    br(4'h8, d); chk("R10 disabled count", d, sw(0, 0, 0, 16'd7));
    p0 = pulses;
    repeat (100) @(posedge clk);
    br(4'h8, d); chk("R10 count frozen", d, sw(0, 0, 0, 16'd7));
    chk("R10 no pulse", 32'(pulses), 32'(p0));
  endtask

  task automatic t_collide;
    logic [31:0] d;
    int p0;
    unlock(cw(1, 0, 0, 16'd5));
    p0 = pulses;
    repeat (3) @(posedge clk);
    bw(4'h0, 32'h00BE_0000);
    bw(4'h0, cw(1, 0, 0, 16'd5) | 32'h00DC_0000);
    chk("R11 no pulse on commit edge", {31'd0, expire_o}, 32'd0);
    chk("R11 pulse count", 32'(pulses), 32'(p0));
    br(4'h8, d); chk("R11 count reloaded", d, sw(1, 0, 0, 16'd5));
    repeat (8) @(posedge clk);
    chk("R11 later expiry", 32'(pulses), 32'(p0 + 1));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_lock();
    t_abort();
    t_status_ro();
    t_config();
    t_run(0, 1, 40);
    t_run(2, 0, 40);
    t_run(3, 2, 1);
    t_run(3, 3, 3);
    t_service();
    t_disable();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miss++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule